// File: doc/BRIEF.md
# Three-Phase Command-Buffered SPI Master

This block is a memory-mapped SPI master meant to drive serial flash devices. Software loads a 32-bit command word and a 32-byte data buffer, sets a bit count for each of three phases (command out, data out, data in) and then writes a start bit. The engine then clocks out the command bits, then the outgoing data bits taken from the buffer, then clocks in the incoming bits and stores them back into the same buffer. A busy flag stays set until every phase has run.

The serial side runs only in clock mode 0. A 12-bit divider sets the serial clock to the system clock divided by (divider + 2). Data bytes go out most-significant bit first unless the configuration asks for least-significant bit first. Two active-low select lines are driven straight from a software register, so software frames a flash command over as many transfers as it needs.

Top module: `spi_flash_master`

## Requirements
- R1: After reset every register reads zero, busy (control bit 16) reads 0, SCK and MOSI are low and both `cs_n` pins are high.
- R2: Writing a word with bit 8 set to the control register at 0x00 starts a transfer when the total bit count is non-zero. Bit 16 of that register then reads 1 for exactly (cmd+tx+rx)*(D+2) system clocks.
- R3: A start write while busy is set has no effect on the running transfer. A start with all three counts zero leaves busy at 0.
- R4: Phases run back to back as command, then transmit, then receive, with no idle clocks between them. A phase with a zero count is skipped, and exactly cmd+tx+rx rising SCK edges occur.
- R5: Command bits leave from bit 31 of the command register (0x04) downward.
- R6: Transmit bits come from buffer bytes in ascending order, where buffer byte i sits in the word at 0x08+4*(i/4), bits [8*(i%4)+7 : 8*(i%4)]. Bits go MSB first, or LSB first when bit 3 of the configuration register (0x28) is 1.
- R7: Received bit k is written into buffer byte k/8, at bit 7-(k%8) for MSB-first order or bit k%8 for LSB-first order. All buffer bits not received keep their values.
- R8: With divider D in configuration bits [27:16], each bit lasts D+2 system clocks. SCK is low for floor((D+2)/2) of them and high for the rest.
- R9: SCK idles low. MOSI changes only when SCK falls or a transfer starts, MISO is sampled on the clock that raises SCK, and MOSI is low during the receive phase and when idle.
- R10: Bits [1:0] of the select register at 0x38 drive `cs_n` inverted. A 1 pulls the matching pin low, and this holds whether or not a transfer is running.
- R11: The command register, the buffer words, configuration (divider and bit-order bit) and the count register (command count [29:24], receive count [20:12], transmit count [8:0]) read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Byte address of the word-aligned register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low device selects |

## Verification
The assertions take for granted that the command count never goes above 32 and that the transmit and receive counts never go above 256. They also take for granted that software leaves the buffer, command, configuration and count registers alone while busy is set, and that the bus holds `reg_we` low during reset. The stimulus draws each count inside its legal range and each divider from a small range, with one directed run at the largest divider. It only writes the control register during a transfer, to test that a repeated start has no effect.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
    localparam int OFS_CTRL  = 0;
    localparam int OFS_CMD   = 4;
    localparam int OFS_BUF   = 8;
    localparam int OFS_CFG   = 40;
    localparam int OFS_CNT   = 44;
    localparam int OFS_CS    = 56;
    localparam int START_POS = 8;
    localparam int BUSY_POS  = 16;
    localparam int DIV_POS   = 16;
    localparam int LSB_POS   = 3;
    localparam int NCMD_POS  = 24;
    localparam int NRX_POS   = 12;
    localparam int NTX_POS   = 0;
endpackage

// File: rtl/spi_fm_timer.sv
module spi_fm_timer #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             rise,
    output logic             fall
);
    localparam int CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] period_m1, half;

    always_comb begin
        period_m1 = {1'b0, div} + CNT_W'(1);
        half      = ({1'b0, div} + CNT_W'(2)) >> 1;
        rise      = run && (cnt_q == half - CNT_W'(1));
        fall      = run && (cnt_q == period_m1);
        if (!run || fall) cnt_d = '0;
        else              cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_fm_bitsel.sv
module spi_fm_bitsel #(
    parameter int CMD_BITS  = 32,
    parameter int BUF_BYTES = 32,
    parameter int IDX_W     = 10,
    parameter int CMD_W     = 6,
    parameter int LEN_W     = 9,
    parameter int BIDX_W    = 5
) (
    input  logic [IDX_W-1:0]          idx,
    input  logic [CMD_W-1:0]          ncmd,
    input  logic [LEN_W-1:0]          ntx,
    input  logic [CMD_BITS-1:0]       cmd,
    input  logic [BUF_BYTES-1:0][7:0] dbuf,
    input  logic                      lsb,
    output logic                      out_bit,
    output logic                      in_rx,
    output logic [BIDX_W-1:0]         rx_byte,
    output logic [2:0]                rx_pos
);
    logic [IDX_W-1:0]    rel_tx, rel_rx;
    logic [CMD_BITS-1:0] cmd_sh;
    logic [BIDX_W-1:0]   tx_byte;
    logic [2:0]          tx_pos;

    always_comb begin
        rel_tx  = idx - IDX_W'(ncmd);
        rel_rx  = rel_tx - IDX_W'(ntx);
        cmd_sh  = cmd << idx;
        tx_byte = rel_tx[3 +: BIDX_W];
        tx_pos  = lsb ? rel_tx[2:0] : ~rel_tx[2:0];
        rx_byte = rel_rx[3 +: BIDX_W];
        rx_pos  = lsb ? rel_rx[2:0] : ~rel_rx[2:0];
        out_bit = 1'b0;
        in_rx   = 1'b0;
        if (idx < IDX_W'(ncmd))        out_bit = cmd_sh[CMD_BITS-1];
        else if (rel_tx < IDX_W'(ntx)) out_bit = dbuf[tx_byte][tx_pos];
        else                           in_rx   = 1'b1;
    end

    logic unused_rel;
    assign unused_rel = ^rel_rx;
endmodule

// File: rtl/spi_flash_master.sv
module spi_flash_master
    import spi_fm_pkg::*;
#(
    parameter int CMD_BITS  = 32,
    parameter int BUF_BYTES = 32,
    parameter int DIV_W     = 12,
    parameter int NUM_CS    = 2,
    parameter int ADDR_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);
    localparam int BUF_BITS = BUF_BYTES * 8;
    localparam int LEN_W    = $clog2(BUF_BITS + 1);
    localparam int CMD_W    = $clog2(CMD_BITS + 1);
    localparam int IDX_W    = $clog2(CMD_BITS + 2 * BUF_BITS + 1);
    localparam int BIDX_W   = $clog2(BUF_BYTES);
    localparam int WIDX_W   = BIDX_W - 2;

    typedef struct packed {
        logic                      busy;
        logic [IDX_W-1:0]          bidx;
        logic                      sck;
        logic                      mosi;
        logic [CMD_BITS-1:0]       cmd;
        logic [BUF_BYTES-1:0][7:0] dbuf;
        logic [DIV_W-1:0]          div;
        logic                      lsb;
        logic [CMD_W-1:0]          ncmd;
        logic [LEN_W-1:0]          ntx;
        logic [LEN_W-1:0]          nrx;
        logic [NUM_CS-1:0]         csel;
    } state_t;

    state_t st_d, st_q;

    logic              rise, fall, busy_w;
    logic [IDX_W-1:0]  total, nxt_idx;
    logic              nxt_bit, cur_rx;
    logic [BIDX_W-1:0] cur_byte;
    logic [2:0]        cur_pos;
    logic              nxt_rx_unused, cur_bit_unused;
    logic [BIDX_W-1:0] nxt_byte_unused;
    logic [2:0]        nxt_pos_unused;
    logic [ADDR_W-1:0] buf_off;
    logic [WIDX_W-1:0] widx;
    logic              in_buf, start_req;

    assign busy_w  = st_q.busy;
    assign total   = IDX_W'(st_q.ncmd) + IDX_W'(st_q.ntx) + IDX_W'(st_q.nrx);
    assign nxt_idx = st_q.busy ? st_q.bidx + IDX_W'(1) : '0;

    spi_fm_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(st_q.busy), .div(st_q.div),
        .rise(rise), .fall(fall)
    );

    spi_fm_bitsel #(
        .CMD_BITS(CMD_BITS), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W),
        .CMD_W(CMD_W), .LEN_W(LEN_W), .BIDX_W(BIDX_W)
    ) u_next (
        .idx(nxt_idx), .ncmd(st_q.ncmd), .ntx(st_q.ntx), .cmd(st_q.cmd),
        .dbuf(st_q.dbuf), .lsb(st_q.lsb), .out_bit(nxt_bit),
        .in_rx(nxt_rx_unused), .rx_byte(nxt_byte_unused), .rx_pos(nxt_pos_unused)
    );

    spi_fm_bitsel #(
        .CMD_BITS(CMD_BITS), .BUF_BYTES(BUF_BYTES), .IDX_W(IDX_W),
        .CMD_W(CMD_W), .LEN_W(LEN_W), .BIDX_W(BIDX_W)
    ) u_cur (
        .idx(st_q.bidx), .ncmd(st_q.ncmd), .ntx(st_q.ntx), .cmd(st_q.cmd),
        .dbuf(st_q.dbuf), .lsb(st_q.lsb), .out_bit(cur_bit_unused),
        .in_rx(cur_rx), .rx_byte(cur_byte), .rx_pos(cur_pos)
    );

    always_comb begin
        buf_off   = reg_addr - ADDR_W'(OFS_BUF);
        widx      = buf_off[2 +: WIDX_W];
        in_buf    = (reg_addr >= ADDR_W'(OFS_BUF)) &&
                    (reg_addr < ADDR_W'(OFS_BUF + BUF_BYTES));
        start_req = reg_we && (reg_addr == ADDR_W'(OFS_CTRL)) && reg_wdata[START_POS];
        st_d      = st_q;

        // Register writes; setup registers are frozen while a transfer runs
        if (reg_we) begin
            if (reg_addr == ADDR_W'(OFS_CS)) st_d.csel = reg_wdata[NUM_CS-1:0];
            if (!st_q.busy) begin
                if (reg_addr == ADDR_W'(OFS_CMD)) st_d.cmd = reg_wdata[CMD_BITS-1:0];
                if (reg_addr == ADDR_W'(OFS_CFG)) begin
                    st_d.div = reg_wdata[DIV_POS +: DIV_W];
                    st_d.lsb = reg_wdata[LSB_POS];
                end
                if (reg_addr == ADDR_W'(OFS_CNT)) begin
                    st_d.ncmd = reg_wdata[NCMD_POS +: CMD_W];
                    st_d.nrx  = reg_wdata[NRX_POS +: LEN_W];
                    st_d.ntx  = reg_wdata[NTX_POS +: LEN_W];
                end
                if (in_buf) begin
                    for (int b = 0; b < 4; b++)
                        st_d.dbuf[{widx, 2'(b)}] = reg_wdata[8*b +: 8];
                end
            end
        end

        // Transfer sequencer
        if (!st_q.busy) begin
            if (start_req && total != '0) begin
                st_d.busy = 1'b1;
                st_d.bidx = '0;
                st_d.sck  = 1'b0;
                st_d.mosi = nxt_bit;
            end
        end else begin
            if (rise) begin
                st_d.sck = 1'b1;
                if (cur_rx) st_d.dbuf[cur_byte][cur_pos] = miso;
            end
            if (fall) begin
                st_d.sck = 1'b0;
                if (st_q.bidx == total - IDX_W'(1)) begin
                    st_d.busy = 1'b0;
                    st_d.bidx = '0;
                    st_d.mosi = 1'b0;
                end else begin
                    st_d.bidx = nxt_idx;
                    st_d.mosi = nxt_bit;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CTRL)) reg_rdata[BUSY_POS] = busy_w;
        if (reg_addr == ADDR_W'(OFS_CMD))  reg_rdata[CMD_BITS-1:0] = st_q.cmd;
        if (reg_addr == ADDR_W'(OFS_CFG)) begin
            reg_rdata[DIV_POS +: DIV_W] = st_q.div;
            reg_rdata[LSB_POS]          = st_q.lsb;
        end
        if (reg_addr == ADDR_W'(OFS_CNT)) begin
            reg_rdata[NCMD_POS +: CMD_W] = st_q.ncmd;
            reg_rdata[NRX_POS +: LEN_W]  = st_q.nrx;
            reg_rdata[NTX_POS +: LEN_W]  = st_q.ntx;
        end
        if (reg_addr == ADDR_W'(OFS_CS)) reg_rdata[NUM_CS-1:0] = st_q.csel;
        if (in_buf) begin
            for (int b = 0; b < 4; b++)
                reg_rdata[8*b +: 8] = st_q.dbuf[{widx, 2'(b)}];
        end
    end

    assign sck  = st_q.sck;
    assign mosi = st_q.mosi;
    assign cs_n = ~st_q.csel;

    logic unused_ok;
    assign unused_ok = ^{nxt_rx_unused, nxt_byte_unused, nxt_pos_unused, cur_bit_unused, buf_off, reg_wdata};
endmodule

// File: rtl/spi_fm_checker.sv
module spi_fm_checker
    import spi_fm_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic              busy,
    input logic              sck,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_n
);
    assert_idle_sck_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sck);

    assert_idle_mosi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mosi);

    assert_sck_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> busy);

    assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(reg_we && reg_addr == ADDR_W'(OFS_CTRL) && reg_wdata[START_POS]));

    assert_end_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $fell(sck));

    assert_cs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(OFS_CS)) |=> (cs_n == ~$past(reg_wdata[NUM_CS-1:0])));
endmodule

bind spi_flash_master spi_fm_checker #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy_w), .sck(sck), .mosi(mosi), .cs_n(cs_n)
);

// File: tb/sim_spi_flash_master.sv
module sim_spi_flash_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck, mosi, miso;
    logic [1:0]  cs_n;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    spi_flash_master u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    // Serial-side model: records MOSI at each rising SCK, presents pattern on MISO
    logic         mon_clr = 1'b0;
    int           nrise;
    logic [575:0] obs;
    logic [575:0] pat = '0;
    int           busy_cyc;
    int           mode_err;
    logic         sck_prev, mosi_prev;

    assign miso = pat[nrise];

    always @(posedge sck or posedge mon_clr) begin
        if (mon_clr) nrise <= 0;
        else begin
            obs[nrise] <= mosi;
            nrise      <= nrise + 1;
        end
    end

    always @(negedge clk or posedge mon_clr) begin
        if (mon_clr) begin
            busy_cyc <= 0;
            mode_err <= 0;
        end else begin
            if (reg_addr == 6'h00 && reg_rdata[16]) busy_cyc <= busy_cyc + 1;
            if (sck_prev && sck && mosi != mosi_prev) mode_err <= mode_err + 1;
        end
        sck_prev  <= sck;
        mosi_prev <= mosi;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 6'h00; reg_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
        reg_addr = 6'h00;
    endtask

    function automatic logic [31:0] cnt_word(int nc, int nt, int nr);
        return (32'(nc) << 24) | (32'(nr) << 12) | 32'(nt);
    endfunction

    function automatic int bitpos(int k, bit lsb);
        return lsb ? (k % 8) : (7 - (k % 8));
    endfunction

    logic [7:0] mb [32];

    task automatic run_xfer(input int nc, input int nt, input int nr, input int dv,
                            input bit lsb, input bit inject);
        logic [31:0] cmd, rv;
        int total, err, guard;
        cmd = $urandom;
        for (int i = 0; i < 32; i++) mb[i] = 8'($urandom);
        for (int w = 0; w < 18; w++) pat[32*w +: 32] = $urandom;
        wr(6'h04, cmd);
        for (int w = 0; w < 8; w++) wr(6'(8 + 4*w), {mb[4*w+3], mb[4*w+2], mb[4*w+1], mb[4*w]});
        wr(6'h28, (32'(dv) << 16) | (32'(lsb) << 3));
        wr(6'h2C, cnt_word(nc, nt, nr));
        @(negedge clk); mon_clr = 1'b1; #1 mon_clr = 1'b0;
        total = nc + nt + nr;
        wr(6'h00, 32'h100);
        if (inject) begin
            repeat (5) @(negedge clk);
            wr(6'h00, 32'h100); // R3: repeated start during busy
        end
        guard = 0;
        while (reg_rdata[16] && guard < 20000) begin @(negedge clk); guard++; end
        @(negedge clk);
        chk(busy_cyc == total * (dv + 2), "R2/R8 busy length", busy_cyc, total * (dv + 2));
        if (inject) chk(busy_cyc == total * (dv + 2), "R3 start while busy", busy_cyc, total * (dv + 2));
        chk(nrise == total, "R4 sck edges", nrise, total);
        chk(mode_err == 0 && !sck && !mosi, "R9 mode0 and idle", mode_err, 0);
        err = 0;
        for (int b = 0; b < nc; b++) if (obs[b] !== cmd[31-b]) err++;
        chk(err == 0, "R5 command bits", err, 0);
        err = 0;
        for (int k = 0; k < nt; k++) if (obs[nc+k] !== mb[k/8][bitpos(k, lsb)]) err++;
        chk(err == 0, "R6 transmit bits", err, 0);
        for (int k = 0; k < nr; k++) mb[k/8][bitpos(k, lsb)] = pat[nc+nt+k];
        err = 0;
        for (int w = 0; w < 8; w++) begin
            rd(6'(8 + 4*w), rv);
            if (rv !== {mb[4*w+3], mb[4*w+2], mb[4*w+1], mb[4*w]}) err++;
        end
        chk(err == 0, "R7 received buffer", err, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        process::self().srandom(32'h5A17);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(6'h00, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(6'h04, v); chk(v == 0, "R1 cmd", v, 0);
        rd(6'h28, v); chk(v == 0, "R1 cfg", v, 0);
        rd(6'h2C, v); chk(v == 0, "R1 counts", v, 0);
        rd(6'h08, v); chk(v == 0, "R1 buffer", v, 0);
        chk(cs_n == 2'b11 && !sck && !mosi, "R1 pins", {cs_n, sck, mosi}, 4'b1100);
        // R11 readback
        wr(6'h04, 32'hA5C3_0F1E); rd(6'h04, v); chk(v == 32'hA5C3_0F1E, "R11 cmd", v, 32'hA5C3_0F1E);
        wr(6'h28, 32'h0ABC_0008); rd(6'h28, v); chk(v == 32'h0ABC_0008, "R11 cfg", v, 32'h0ABC_0008);
        wr(6'h2C, cnt_word(32, 256, 256)); rd(6'h2C, v);
        chk(v == cnt_word(32, 256, 256), "R11 counts", v, cnt_word(32, 256, 256));
        wr(6'h24, 32'h1234_5678); rd(6'h24, v); chk(v == 32'h1234_5678, "R11 buffer", v, 32'h1234_5678);
        // R10 chip selects
        wr(6'h38, 32'h1); @(negedge clk); chk(cs_n == 2'b10, "R10 cs0", cs_n, 2'b10);
        wr(6'h38, 32'h2); @(negedge clk); chk(cs_n == 2'b01, "R10 cs1", cs_n, 2'b01);
        wr(6'h38, 32'h0); @(negedge clk); chk(cs_n == 2'b11, "R10 none", cs_n, 2'b11);
        // R3 zero-length start
        wr(6'h2C, 32'h0); wr(6'h00, 32'h100);
        repeat (3) @(negedge clk);
        rd(6'h00, v); chk(v == 0 && !sck, "R3 zero counts", v, 0);
        // Directed phase mixes
        wr(6'h38, 32'h1);
        run_xfer(8, 0, 0, 0, 1'b0, 1'b0);
        run_xfer(0, 16, 0, 1, 1'b1, 1'b0);
        run_xfer(0, 0, 12, 2, 1'b0, 1'b0);
        run_xfer(0, 5, 11, 3, 1'b1, 1'b0);
        run_xfer(32, 256, 256, 0, 1'b0, 1'b1);
        run_xfer(1, 1, 1, 4095, 1'b0, 1'b0);
        chk(cs_n == 2'b10, "R10 held across transfers", cs_n, 2'b10);
        // Random mixes
        for (int t = 0; t < 12; t++)
            run_xfer(int'($urandom % 33), int'($urandom % 257), int'($urandom % 257),
                     int'($urandom % 4), 1'($urandom), (t % 4) == 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule